// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block produces the 1 ms frame cadence of a full-speed USB host controller. A 12 MHz bit-time enable steps a down-counter that is loaded from a programmable interval value. Each time the counter expires, a new frame begins: the counter reloads, a 16-bit frame number advances, and a one-cycle start-of-frame pulse is raised. A second pulse marks each change of the frame number's top bit, so software can extend the frame count beyond 16 bits.

Software sees three 32-bit words through a simple write port and a combinational read port. The first is the interval word, which also holds the largest full-speed packet size and a toggle flag. The second is the remaining word, which shows the live count and the toggle copy. The third is the frame number. The toggle flips only when software writes an interval that differs from the stored one. The toggle is copied into the remaining word at every frame boundary, so software can tell when its new interval has taken effect. An operational-state input starts and stops frame generation.

Top module: `sof_frame_timer`

## Requirements
- R1: After a synchronous reset, the interval word reads 0x2778_2EDF (interval 0x2EDF, packet size 0x2778, toggle 0). The remaining word and the frame number read 0, and neither pulse output is high.
- R2: The interval word holds the interval in bits 13:0, the maximum packet size in bits 30:16 and the toggle in bit 31, with bits 15:14 reading 0. A write with select 0 updates the interval and the packet size. Written bits 31 and 15:14 are ignored.
- R3: A write with select 0 whose bits 13:0 differ from the stored interval inverts the toggle. A write with an equal value leaves the toggle unchanged.
- R4: While operational, each cycle with bit_tick high decrements the count. A tick at count 0 is a frame boundary and reloads the interval, so a frame lasts interval+1 ticks (12000 ticks, 1 ms at 12 MHz, for 0x2EDF). Without a tick the count holds.
- R5: At a frame boundary the frame number increases by one, and sof_pulse is high for exactly the following cycle.
- R6: At a frame boundary, bit 31 of the remaining word is loaded from the toggle.
- R7: The remaining word reads {toggle copy, 17 zeros, count} while operational. Otherwise it reads only the toggle copy in bit 31, with all other bits 0.
- R8: While run_en is low the count and frame number hold and sof_pulse stays low. When run_en rises, sof_pulse is high on the next cycle and the count is loaded from the interval, without incrementing the frame number.
- R9: fno_pulse is high for one cycle whenever bit 15 of the frame number changes, that is on 0x7FFF to 0x8000 and on 0xFFFF to 0x0000, and at no other time.
- R10: An interval write in the same cycle as a frame boundary does not affect that boundary. The reload uses the old interval and the toggle copy takes the old toggle. The new interval is used at the next boundary.
- R11: Read select 0 returns the interval word, 1 the remaining word, 2 the frame number in bits 15:0 with upper bits 0, and 3 returns 0. Writes with a select other than 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle enable per 12 MHz bit time |
| run_en | input | 1 | Controller is in the operational state |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data (combinational) |
| frame_num | output | 16 | Current frame number |
| sof_pulse | output | 1 | Start-of-frame pulse |
| fno_pulse | output | 1 | Frame-number bit 15 change pulse |

## Verification
A software write to the interval word can arrive in the same cycle as the bit tick that expires the count. This collision is the case that needs care. The bench counts a frame down to zero and then issues the write on the expiring tick. It checks that the boundary reloads the old interval and copies the old toggle. It then checks that the next boundary uses the new interval and the toggle that the write produced. A start request arriving with a tick in the same cycle is also exercised: the start must take priority, with no decrement.

// File: rtl/ftm_pkg.sv
package ftm_pkg;

    parameter int DW    = 32;
    parameter int FI_W  = 14;
    parameter int MPS_W = 15;
    parameter int FN_W  = 16;

    localparam int GAP_W     = DW - 1 - MPS_W - FI_W;
    localparam int REM_PAD_W = DW - 1 - FI_W;
    localparam int FN_PAD_W  = DW - FN_W;

    localparam logic [FI_W-1:0]  FI_RST  = FI_W'(14'h2EDF);
    localparam logic [MPS_W-1:0] MPS_RST = MPS_W'(15'h2778);

    typedef enum logic [1:0] {
        SEL_INTERVAL = 2'd0,
        SEL_REMAIN   = 2'd1,
        SEL_FRNUM    = 2'd2,
        SEL_NONE     = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic              toggle;
        logic [MPS_W-1:0]  max_pkt;
        logic [FI_W-1:0]   interval;
    } ival_t;

    function automatic logic [DW-1:0] ival_to_word(input ival_t v);
        return {v.toggle, v.max_pkt, {GAP_W{1'b0}}, v.interval};
    endfunction

    function automatic logic [DW-1:0] remain_to_word(input logic tgl,
                                                     input logic running,
                                                     input logic [FI_W-1:0] cnt);
        if (running)
            return {tgl, {REM_PAD_W{1'b0}}, cnt};
        return {tgl, {(DW-1){1'b0}}};
    endfunction

    function automatic logic [DW-1:0] frnum_to_word(input logic [FN_W-1:0] fn);
        return {{FN_PAD_W{1'b0}}, fn};
    endfunction

endpackage

// File: rtl/ftm_interval_reg.sv
module ftm_interval_reg
    import ftm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [FI_W-1:0]  wr_interval,
    input  logic [MPS_W-1:0] wr_max_pkt,
    output ival_t            ival_q
);

    logic differs;
    assign differs = (wr_interval != ival_q.interval);

    always_ff @(posedge clk) begin
        if (rst) begin
            ival_q.toggle   <= 1'b0;
            ival_q.max_pkt  <= MPS_RST;
            ival_q.interval <= FI_RST;
        end else if (wr_en) begin
            ival_q.max_pkt  <= wr_max_pkt;
            ival_q.interval <= wr_interval;
            if (differs)
                ival_q.toggle <= ~ival_q.toggle;
        end
    end

    // R3: a differing interval flips the toggle
    a_r3_toggle_flip: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_interval != ival_q.interval)) |=> (ival_q.toggle != $past(ival_q.toggle)));

    // R3: an equal interval keeps the toggle
    a_r3_toggle_keep: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_interval == ival_q.interval)) |=> $stable(ival_q.toggle));

    // R2: without a write the register holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ival_q));

endmodule

// File: rtl/ftm_down_counter.sv
module ftm_down_counter
    import ftm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_tick,
    input  logic            run_en,
    input  logic [FI_W-1:0] reload_val,
    input  logic            toggle_in,
    output logic [FI_W-1:0] count_q,
    output logic            rem_toggle_q,
    output logic            running,
    output logic            boundary,
    output logic            sof_q
);

    run_state_e state_q;
    logic       start_c;
    logic       active;
    logic       expired;

    assign running  = (state_q == ST_RUN);
    assign start_c  = (state_q == ST_IDLE) && run_en;
    assign active   = running && run_en;
    assign expired  = (count_q == '0);
    assign boundary = active && bit_tick && expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            count_q      <= '0;
            rem_toggle_q <= 1'b0;
            sof_q        <= 1'b0;
        end else begin
            state_q <= run_en ? ST_RUN : ST_IDLE;
            sof_q   <= start_c | boundary;
            if (start_c) begin
                count_q <= reload_val;
            end else if (active && bit_tick) begin
                if (expired) begin
                    count_q      <= reload_val;
                    rem_toggle_q <= toggle_in;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
        end
    end

    // R4: a tick away from zero decrements by one
    a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
        (running && run_en && bit_tick && (count_q != '0)) |=> (count_q == $past(count_q) - 1'b1));

    // R4: no tick, no movement
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (running && run_en && !bit_tick) |=> $stable(count_q));

    // R6 / R10: boundary copies the toggle seen before the edge
    a_r6_toggle_copy: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (rem_toggle_q == $past(toggle_in)));

    // R8: no start-of-frame while stopped
    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !sof_q);

    // R8: starting loads the interval and signals a frame
    a_r8_start: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && run_en) |=> (sof_q && (count_q == $past(reload_val))));

endmodule

// File: rtl/ftm_frame_number.sv
module ftm_frame_number
    import ftm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    output logic [FN_W-1:0] frame_q,
    output logic            wrap_q
);

    logic carry_top;
    assign carry_top = &frame_q[FN_W-2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            wrap_q  <= 1'b0;
        end else begin
            wrap_q <= advance && carry_top;
            if (advance)
                frame_q <= frame_q + 1'b1;
        end
    end

    // R5: each boundary adds one
    a_r5_increment: assert property (@(posedge clk) disable iff (rst)
        advance |=> (frame_q == $past(frame_q) + 1'b1));

    // R8: frame number holds between boundaries
    a_r8_frame_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(frame_q));

    // R9: pulse only accompanies a change of the top bit
    a_r9_pulse_on_top: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> (frame_q[FN_W-1] != $past(frame_q[FN_W-1])));

    // R9: a change of the top bit is always flagged
    a_r9_top_flagged: assert property (@(posedge clk) disable iff (rst)
        (frame_q[FN_W-1] != $past(frame_q[FN_W-1])) |-> wrap_q);

endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer
    import ftm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_tick,
    input  logic            run_en,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic [1:0]      rd_sel,
    output logic [DW-1:0]   rd_data,
    output logic [FN_W-1:0] frame_num,
    output logic            sof_pulse,
    output logic            fno_pulse
);

    ival_t           ival_q;
    logic            ival_wr;
    logic [FI_W-1:0] count_q;
    logic            rem_toggle_q;
    logic            running;
    logic            boundary;
    logic            unused_wr_bits;

    assign ival_wr        = wr_en && (reg_sel_e'(wr_sel) == SEL_INTERVAL);
    assign unused_wr_bits = ^{wr_data[DW-1], wr_data[FI_W+GAP_W-1:FI_W]};

    ftm_interval_reg u_ival (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (ival_wr),
        .wr_interval (wr_data[FI_W-1:0]),
        .wr_max_pkt  (wr_data[DW-2 -: MPS_W]),
        .ival_q      (ival_q)
    );

    ftm_down_counter u_cnt (
        .clk          (clk),
        .rst          (rst),
        .bit_tick     (bit_tick),
        .run_en       (run_en),
        .reload_val   (ival_q.interval),
        .toggle_in    (ival_q.toggle),
        .count_q      (count_q),
        .rem_toggle_q (rem_toggle_q),
        .running      (running),
        .boundary     (boundary),
        .sof_q        (sof_pulse)
    );

    ftm_frame_number u_fn (
        .clk     (clk),
        .rst     (rst),
        .advance (boundary),
        .frame_q (frame_num),
        .wrap_q  (fno_pulse)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_INTERVAL: rd_data = ival_to_word(ival_q);
            SEL_REMAIN:   rd_data = remain_to_word(rem_toggle_q, running, count_q);
            SEL_FRNUM:    rd_data = frnum_to_word(frame_num);
            default:      rd_data = '0;
        endcase
    end

    // R5: start-of-frame pulses last one cycle while the bit clock runs each cycle
    a_r5_sof_single: assert property (@(posedge clk) disable iff (rst)
        (sof_pulse && run_en && bit_tick && (count_q != '0)) |=> !sof_pulse);

endmodule

// File: tb/sim_sof_frame_timer.sv
module sim_sof_frame_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [15:0] frame_num;
    logic        sof_pulse;
    logic        fno_pulse;

    int n_checks = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sof_frame_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .run_en    (run_en),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .frame_num (frame_num),
        .sof_pulse (sof_pulse),
        .fno_pulse (fno_pulse)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [1:0] s, output logic [31:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic do_write(input logic [1:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        read_reg(2'd0, v); check("R1 interval reset", v, 32'h2778_2EDF);
        read_reg(2'd1, v); check("R1 remaining reset", v, 32'h0);
        read_reg(2'd2, v); check("R1 frame reset", v, 32'h0);
        read_reg(2'd3, v); check("R11 unused select", v, 32'h0);
        check("R1 sof reset", {31'b0, sof_pulse}, 32'h0);
        check("R1 fno reset", {31'b0, fno_pulse}, 32'h0);
    endtask

    task automatic test_writes();
        logic [31:0] v;
        do_write(2'd0, 32'h9234_C005);
        read_reg(2'd0, v); check("R2 R3 layout and flip", v, 32'h9234_0005);
        do_write(2'd0, 32'h0567_0005);
        read_reg(2'd0, v); check("R3 equal keeps toggle", v, 32'h8567_0005);
        do_write(2'd0, 32'h0567_0006);
        read_reg(2'd0, v); check("R3 differing flips back", v, 32'h0567_0006);
        do_write(2'd1, 32'hFFFF_FFFF);
        do_write(2'd2, 32'hFFFF_FFFF);
        do_write(2'd3, 32'hFFFF_FFFF);
        read_reg(2'd0, v); check("R11 other selects ignored", v, 32'h0567_0006);
        read_reg(2'd2, v); check("R11 frame untouched", v, 32'h0);
        do_write(2'd0, 32'h0567_0005);
        read_reg(2'd0, v); check("R3 flip again", v, 32'h8567_0005);
    endtask

    task automatic test_start_count();
        logic [31:0] v;
        run_en = 1'b1;
        step();
        check("R8 sof on start", {31'b0, sof_pulse}, 32'h1);
        read_reg(2'd1, v); check("R7 R8 remaining after start", v, 32'h0000_0005);
        read_reg(2'd2, v); check("R8 no increment on start", v, 32'h0);
        step();
        check("R5 sof single cycle", {31'b0, sof_pulse}, 32'h0);
        read_reg(2'd1, v); check("R4 hold without tick", v, 32'h0000_0005);
        bit_tick = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            step();
            read_reg(2'd1, v); check("R4 countdown", v, 32'(5 - i));
            check("R5 no sof mid frame", {31'b0, sof_pulse}, 32'h0);
        end
        step();
        check("R5 sof at boundary", {31'b0, sof_pulse}, 32'h1);
        check("R5 frame incremented", {16'b0, frame_num}, 32'h1);
        read_reg(2'd1, v); check("R6 toggle copied", v, 32'h8000_0005);
        for (int i = 1; i <= 6; i++) begin
            step();
            check("R4 frame length interval+1", {31'b0, sof_pulse}, (i == 6) ? 32'h1 : 32'h0);
        end
        check("R5 second frame", {16'b0, frame_num}, 32'h2);
    endtask

    task automatic test_stop_restart();
        logic [31:0] v;
        run_en = 1'b0;
        step();
        read_reg(2'd1, v); check("R7 idle reads toggle only", v, 32'h8000_0000);
        check("R8 no sof when stopped", {31'b0, sof_pulse}, 32'h0);
        for (int i = 0; i < 20; i++) begin
            step();
            if (sof_pulse) check("R8 sof while stopped", 32'h1, 32'h0);
        end
        check("R8 frame held while stopped", {16'b0, frame_num}, 32'h2);
        run_en = 1'b1;
        step();
        check("R8 sof on restart", {31'b0, sof_pulse}, 32'h1);
        read_reg(2'd1, v); check("R8 reload on restart", v, 32'h8000_0005);
        check("R8 frame same on restart", {16'b0, frame_num}, 32'h2);
    endtask

    task automatic test_collision();
        logic [31:0] v;
        for (int i = 0; i < 5; i++) step();
        read_reg(2'd1, v); check("R4 count reached zero", v, 32'h8000_0000);
        do_write(2'd0, 32'h0567_0003);
        check("R10 boundary still fires", {31'b0, sof_pulse}, 32'h1);
        check("R10 frame incremented", {16'b0, frame_num}, 32'h3);
        read_reg(2'd1, v); check("R10 old interval and toggle used", v, 32'h8000_0005);
        read_reg(2'd0, v); check("R10 write landed", v, 32'h0567_0003);
        for (int i = 0; i < 6; i++) step();
        check("R10 next boundary", {31'b0, sof_pulse}, 32'h1);
        read_reg(2'd1, v); check("R6 R10 new interval and toggle", v, 32'h0000_0003);
        check("R5 frame four", {16'b0, frame_num}, 32'h4);
    endtask

    task automatic test_one_ms();
        int n;
        run_en = 1'b0;
        step();
        do_write(2'd0, 32'h2778_2EDF);
        run_en = 1'b1;
        step();
        check("R8 start before ms frame", {31'b0, sof_pulse}, 32'h1);
        n = 0;
        for (int i = 0; i < 13000; i++) begin
            step();
            n++;
            if (sof_pulse) break;
        end
        check("R4 12000 ticks per frame", 32'(n), 32'd12000);
    endtask

    task automatic test_overflow();
        logic [31:0] v;
        int n_sof;
        int n_fno;
        int bad;
        run_en = 1'b0;
        rst = 1'b1;
        step();
        rst = 1'b0;
        read_reg(2'd0, v); check("R1 interval after mid-run reset", v, 32'h2778_2EDF);
        read_reg(2'd2, v); check("R1 frame after mid-run reset", v, 32'h0);
        do_write(2'd0, 32'h0000_0000);
        run_en = 1'b1;
        step();
        check("R8 start for wrap run", {31'b0, sof_pulse}, 32'h1);
        n_sof = 0; n_fno = 0; bad = 0;
        for (int k = 1; k <= 65536; k++) begin
            step();
            if (sof_pulse) n_sof++;
            if (fno_pulse) n_fno++;
            if (fno_pulse !== ((k == 32768) || (k == 65536))) bad++;
            if (frame_num !== 16'(k)) bad++;
        end
        check("R9 fno pulse placement", 32'(bad), 32'h0);
        check("R9 fno pulse count", 32'(n_fno), 32'd2);
        check("R5 sof every boundary", 32'(n_sof), 32'd65536);
        check("R9 frame wrapped to zero", {16'b0, frame_num}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        step();
        test_reset();
        test_writes();
        test_start_count();
        test_stop_restart();
        test_collision();
        test_one_ms();
        test_overflow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule